// File: doc/BRIEF.md
# Serial Three-Bit Combination Lock Controller

This block guards a door with a short secret code. The code is entered one bit at a time on a two-position key switch. An ENTER button marks each bit. A combination register holds the expected code. It can be rewritten through a load strobe, but only while the controller sits in its start state.

Each press of ENTER opens one compare step. The key bit is compared with the matching bit of the stored combination, lowest bit first. The third bit needs no ENTER after it.

A wrong bit does not show at once. The controller moves onto a parallel failure track. That track takes the remaining presses and bits exactly like the success track, so an observer cannot tell when the first wrong bit went in. After the last bit the controller raises either an unlock output or an error output. That output holds until reset.

Top module: `comb_lock_top`

## Requirements
- R1: While reset is held and after it is released, unlock and error are both 0, and the controller is in its start state, where a load is accepted.
- R2: A load (load_en high for one clock in the start state) stores load_code. Bit i of the stored code is compared with the i-th entered key bit, and the first bit entered is bit 0.
- R3: A load strobe outside the start state leaves the stored combination unchanged.
- R4: A press counts once, on the rising edge of enter_in, however many clocks the button stays high.
- R5: The key bit for a step is sampled on the second rising clock edge after the edge that first sees enter_in high. Its value on other edges does not matter.
- R6: After three presses whose key bits all match the combination, unlock goes to 1 and error stays 0. No press follows the third bit.
- R7: If any entered bit differs from the combination, error goes to 1 only after the third bit. Both outputs stay 0 after the first and second bits, whether they matched or not.
- R8: Once unlock or error is set, it stays set and the other output stays 0 until reset. Further presses and key changes have no effect.
- R9: Asserting reset in any state, including partway through entry, clears both outputs and returns to the start state. A later full entry then behaves as in R6 and R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enter_in | input | 1 | ENTER button level; a rising edge starts one bit step |
| key_in | input | 1 | Key switch bit |
| load_en | input | 1 | Combination load strobe, honoured only in the start state |
| load_code | input | CODE_W (3) | New combination; bit 0 is checked first |
| unlock | output | 1 | Correct code entered; held until reset |
| error | output | 1 | Wrong code entered; held until reset |

## Verification
The assertions assume that enter_in and key_in are already synchronous to clk and free of bounce. They also assume that the key bit is steady on the edge where it is sampled. The bench changes every input only on falling clock edges. It leaves at least four clocks between presses, so each press ends its compare step before the next one arrives. The timing test moves the key switch on the clocks just before and just after the sampling edge. Load strobes are issued both in the start state and partway through entry.

// File: rtl/lock_pkg.sv
package lock_pkg;
  typedef enum logic [2:0] {
    ST_START = 3'd0,
    ST_CMP   = 3'd1,
    ST_WAIT  = 3'd2,
    ST_ECMP  = 3'd3,
    ST_EWAIT = 3'd4,
    ST_DONE  = 3'd5,
    ST_FAIL  = 3'd6
  } lock_state_t;
endpackage

// File: rtl/lock_rst_sync.sv
module lock_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sh_q[STAGES-1];
endmodule

// File: rtl/lock_press_edge.sv
module lock_press_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_in,
  output logic press
);
  logic prev_q;
  logic press_q;
  logic press_d;

  always_comb press_d = btn_in & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      press_q <= 1'b0;
    end else begin
      prev_q  <= btn_in;
      press_q <= press_d;
    end
  end

  assign press = press_q;

  // R4
  press_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    press |=> !press);
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import lock_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              press,
  input  logic              key_in,
  input  logic [CODE_W-1:0] comb,
  output logic              in_start,
  output logic              unlock,
  output logic              error
);
  localparam int IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CODE_W - 1);

  lock_state_t      state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;
  logic             bit_ok;
  logic             at_last;

  always_comb begin
    bit_ok  = (key_in == comb[idx_q]);
    at_last = (idx_q == LAST);
    state_d = state_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    case (state_q)
      ST_START: if (press) begin
        state_d = ST_CMP;
        idx_d   = '0;
        idx_en  = 1'b1;
      end
      ST_CMP: begin
        if (bit_ok) state_d = at_last ? ST_DONE : ST_WAIT;
        else        state_d = at_last ? ST_FAIL : ST_EWAIT;
      end
      ST_WAIT: if (press) begin
        state_d = ST_CMP;
        idx_d   = idx_q + 1'b1;
        idx_en  = 1'b1;
      end
      ST_ECMP:  state_d = at_last ? ST_FAIL : ST_EWAIT;
      ST_EWAIT: if (press) begin
        state_d = ST_ECMP;
        idx_d   = idx_q + 1'b1;
        idx_en  = 1'b1;
      end
      ST_DONE:  state_d = ST_DONE;
      ST_FAIL:  state_d = ST_FAIL;
      default:  state_d = ST_START;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_START;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  assign in_start = (state_q == ST_START);
  assign unlock   = (state_q == ST_DONE);
  assign error    = (state_q == ST_FAIL);

  // R8
  unlock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unlock |=> (unlock && !error));
  // R8
  error_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> (error && !unlock));
  // R7
  error_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> ($past(idx_q) == LAST));
  // R6
  unlock_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlock) |-> (($past(idx_q) == LAST) && ($past(key_in) == $past(comb[LAST]))));
endmodule

// File: rtl/comb_lock_top.sv
module comb_lock_top #(
  parameter int CODE_W    = 3,
  parameter int RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enter_in,
  input  logic              key_in,
  input  logic              load_en,
  input  logic [CODE_W-1:0] load_code,
  output logic              unlock,
  output logic              error
);
  logic              rst_s_n;
  logic              press;
  logic              in_start;
  logic              comb_we;
  logic [CODE_W-1:0] comb_q;

  lock_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  lock_press_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .btn_in (enter_in),
    .press  (press)
  );

  assign comb_we = load_en & in_start;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)     comb_q <= '0;
    else if (comb_we) comb_q <= load_code;
  end

  lock_fsm #(.CODE_W(CODE_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .press    (press),
    .key_in   (key_in),
    .comb     (comb_q),
    .in_start (in_start),
    .unlock   (unlock),
    .error    (error)
  );

  // R3
  comb_gate_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !$stable(comb_q) |-> $past(load_en && in_start));
endmodule

// File: tb/comb_lock_top_tb.sv
module comb_lock_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enter_in = 1'b0;
  logic       key_in = 1'b0;
  logic       load_en = 1'b0;
  logic [2:0] load_code = 3'b000;
  logic       unlock;
  logic       error;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  comb_lock_top u_dut (
    .clk(clk), .rst_n(rst_n), .enter_in(enter_in), .key_in(key_in),
    .load_en(load_en), .load_code(load_code), .unlock(unlock), .error(error)
  );

  // {combination, entered code, expected unlock}
  localparam logic [6:0] VEC [8] = '{
    {3'b000, 3'b000, 1'b1}, {3'b101, 3'b101, 1'b1},
    {3'b111, 3'b110, 1'b0}, {3'b010, 3'b011, 1'b0},
    {3'b100, 3'b000, 1'b0}, {3'b110, 3'b110, 1'b1},
    {3'b001, 3'b101, 1'b0}, {3'b011, 3'b011, 1'b1}
  };

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {unlock,error} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic load(input logic [2:0] c);
    @(negedge clk) begin load_en = 1'b1; load_code = c; end
    @(negedge clk) load_en = 1'b0;
  endtask

  task automatic press_bit(input logic b, input int hold);
    @(negedge clk) begin key_in = b; enter_in = 1'b1; end
    repeat (hold) @(negedge clk);
    enter_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic trial(input logic [2:0] c, input logic [2:0] code, input logic exp);
    do_reset();
    load(c);
    for (int i = 0; i < 3; i++) begin
      press_bit(code[i], 1);
      if (i < 2) check("R7 no early result", {unlock, error}, 2'b00);
    end
    check(exp ? "R6 match" : "R7 mismatch", {unlock, error}, {exp, ~exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    check("R1 during reset", {unlock, error}, 2'b00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", {unlock, error}, 2'b00);

    // R2 table of directed vectors
    for (int v = 0; v < 8; v++)
      trial(VEC[v][6:4], VEC[v][3:1], VEC[v][0]);

    // R6 R7 every combination against every code
    for (int c = 0; c < 8; c++)
      for (int k = 0; k < 8; k++)
        trial(3'(c), 3'(k), (c == k));

    // R3 load outside start state ignored
    do_reset();
    load(3'b101);
    press_bit(1'b1, 1);
    load(3'b000);
    press_bit(1'b0, 1);
    press_bit(1'b1, 1);
    check("R3 late load ignored", {unlock, error}, 2'b10);

    // R4 held ENTER counts once
    do_reset();
    load(3'b110);
    press_bit(1'b0, 9);
    check("R4 long hold, one step", {unlock, error}, 2'b00);
    press_bit(1'b1, 5);
    press_bit(1'b1, 7);
    check("R4 held presses", {unlock, error}, 2'b10);

    // R5 key sampled exactly on the second edge after ENTER seen
    do_reset();
    load(3'b010);
    for (int i = 0; i < 3; i++) begin
      logic b;
      b = 1'(3'b010 >> i);
      @(negedge clk) begin key_in = ~b; enter_in = 1'b1; end
      @(negedge clk) enter_in = 1'b0;
      @(negedge clk) key_in = b;
      @(negedge clk) key_in = ~b;
      repeat (3) @(negedge clk);
    end
    check("R5 sampling edge", {unlock, error}, 2'b10);

    // R8 outputs sticky
    press_bit(1'b1, 1);
    press_bit(1'b0, 1);
    press_bit(1'b1, 1);
    check("R8 unlock held", {unlock, error}, 2'b10);
    do_reset();
    load(3'b000);
    press_bit(1'b1, 1);
    press_bit(1'b0, 1);
    press_bit(1'b0, 1);
    press_bit(1'b0, 1);
    press_bit(1'b0, 1);
    press_bit(1'b0, 1);
    check("R8 error held", {unlock, error}, 2'b01);

    // R9 reset mid-entry and from done
    do_reset();
    check("R9 reset clears error", {unlock, error}, 2'b00);
    load(3'b011);
    press_bit(1'b0, 1);
    do_reset();
    check("R9 reset mid entry", {unlock, error}, 2'b00);
    load(3'b011);
    press_bit(1'b1, 1);
    press_bit(1'b1, 1);
    press_bit(1'b0, 1);
    check("R9 fresh entry", {unlock, error}, 2'b10);
    do_reset();
    check("R9 reset clears unlock", {unlock, error}, 2'b00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule